// File: doc/BRIEF.md
# Preset-Mode Minifloat Recursive Filter Section

This block is a streaming filter section whose structure is picked from a small set of classic low-cost filters by a 3-bit mode code. Each accepted input sample is a 12-bit minifloat. It passes first through an optional comb stage, which subtracts the sample taken N inputs earlier. It then passes through a second-order section. That section weights the comb output and its previous value with feedforward taps, and weights the last two outputs with feedback taps. One output sample with a valid flag appears for every accepted input.

Every preset tap is 0, +1, -1 or 1/8. The datapath therefore needs only a minifloat adder, a sign flip and an exponent decrement. It has no general multiplier. Changing the mode code discards the filter history and starts the new structure from zero. A synchronous reset has the same effect. Samples may arrive on every cycle or with gaps.

Top module: `pmf_filter_top`

## Requirements
- R1: Samples are {sign[11], exponent[10:5], fraction[4:0]} with value (-1)^s · 1.f · 2^(e-31). Any word whose exponent is 0 is taken as zero, and every zero result leaves the block as 12'h000.
- R2: Two values are added as follows. The smaller magnitude is shifted right by the exponent difference, dropping the bits shifted out. The sum is renormalised, and an exponent overflow saturates to the largest magnitude (exponent 63, fraction 31) with the larger operand's sign. An exponent underflow gives zero. A tap of 1/8 lowers the exponent by 3 and gives zero if the exponent is 3 or less. The output is evaluated as ((b0·v[n] + b1·v[n-1]) + a1·y[n-1]) + a2·y[n-2].
- R3: Mode 0 (differencer) gives y[n] = x[n] - x[n-1] with the comb stage off.
- R4: Mode 1 (integrator) gives y[n] = x[n] + y[n-1] with the comb stage off.
- R5: Mode 2 (comb) gives y[n] = x[n] - x[n-8].
- R6: Mode 3 (resonator/bandpass) gives y[n] = v[n] - y[n-2], where v[n] = x[n] - x[n-16].
- R7: Mode 4 (CIC interpolator) gives y[n] = v[n] + y[n-1], where v[n] = x[n] - x[n-8].
- R8: Mode 5 (moving average) gives y[n] = v[n]/8 + y[n-1], where v[n] = x[n] - x[n-8].
- R9: Codes 6 and 7 pass the input through: y[n] = x[n].
- R10: The result of an input accepted with in_valid in cycle t appears with out_valid in cycle t+2. Inputs may be accepted on consecutive cycles. out_valid is never raised without a matching input.
- R11: A cycle in which `mode` differs from its value in the previous cycle clears the delay line, all history and any results still in the pipeline. An input offered in that cycle is discarded. In the next cycle out_valid is 0 and out_data is 12'h000.
- R12: During and right after reset, out_valid is 0 and out_data is 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Filter structure select |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Input minifloat sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 12 | Output minifloat sample, held between strobes |

## Verification
The bench builds the block with its default 16-entry delay line and the 6-bit-exponent, 5-bit-fraction format. With these values both comb lengths and every mode code can be swept in one run. Each of the eight codes receives a long pseudo-random stream with gaps. The stream mixes tiny, mid-range and near-maximum exponents, so both truncation paths, renormalisation, saturation and flush-to-zero are reached. The bench compares every output against its own integer model of the minifloat arithmetic. Directed sequences cover the integrator saturating, the 1/8 tap flushing to zero, an exponent-zero input word, and a mode switch landing on a valid input.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int EW   = 6;
  localparam int FW   = 5;
  localparam int DW   = 1 + EW + FW;
  localparam int EMAX = (1 << EW) - 1;

  typedef logic [DW-1:0] fp_t;
  typedef enum logic [1:0] {TAP_ZERO, TAP_POS, TAP_NEG, TAP_EIGHTH} tap_e;

  typedef struct packed {
    logic comb_en;
    logic comb_long;
    tap_e b0;
    tap_e b1;
    tap_e a1;
    tap_e a2;
  } cfg_t;

  function automatic logic [EW-1:0] fp_exp(fp_t x);
    return x[DW-2:FW];
  endfunction

  // exponent zero means zero, whatever the other bits hold
  function automatic fp_t fp_canon(fp_t x);
    return (fp_exp(x) == '0) ? '0 : x;
  endfunction

  function automatic fp_t fp_neg(fp_t x);
    return (fp_exp(x) == '0) ? '0 : {~x[DW-1], x[DW-2:0]};
  endfunction

  function automatic fp_t fp_eighth(fp_t x);
    if (fp_exp(x) <= EW'(3)) return '0;
    return {x[DW-1], fp_exp(x) - EW'(3), x[FW-1:0]};
  endfunction

  function automatic fp_t fp_tap(tap_e t, fp_t x);
    case (t)
      TAP_POS:    return x;
      TAP_NEG:    return fp_neg(x);
      TAP_EIGHTH: return fp_eighth(x);
      default:    return '0;
    endcase
  endfunction

  function automatic fp_t fp_add(fp_t a, fp_t b);
    fp_t big, sml;
    logic [EW-1:0] eb, d;
    logic [FW:0] mb, sh;
    logic [FW+1:0] s;
    int sft;
    if (fp_exp(a) == '0) return (fp_exp(b) == '0) ? '0 : b;
    if (fp_exp(b) == '0) return a;
    if (a[DW-2:0] >= b[DW-2:0]) begin big = a; sml = b; end
    else begin big = b; sml = a; end
    eb = fp_exp(big);
    d  = eb - fp_exp(sml);
    mb = {1'b1, big[FW-1:0]};
    sh = {1'b1, sml[FW-1:0]} >> d;
    if (big[DW-1] == sml[DW-1]) begin
      s = {1'b0, mb} + {1'b0, sh};
      if (s[FW+1]) begin
        if (eb == EW'(EMAX)) return {big[DW-1], {(DW-1){1'b1}}};
        return {big[DW-1], eb + EW'(1), s[FW:1]};
      end
      return {big[DW-1], eb, s[FW-1:0]};
    end
    s = {1'b0, mb - sh};
    if (s == '0) return '0;
    sft = FW + 1;
    for (int i = 0; i <= FW; i++) if (s[i]) sft = FW - i;
    if (int'(eb) <= sft) return '0;
    s = s << sft;
    return {big[DW-1], EW'(int'(eb) - sft), s[FW-1:0]};
  endfunction

  function automatic cfg_t mode_cfg(logic [2:0] m);
    cfg_t c;
    c = '{comb_en: 1'b0, comb_long: 1'b0, b0: TAP_POS, b1: TAP_ZERO,
          a1: TAP_ZERO, a2: TAP_ZERO};
    case (m)
      3'd0: c.b1 = TAP_NEG;
      3'd1: c.a1 = TAP_POS;
      3'd2: c.comb_en = 1'b1;
      3'd3: begin c.comb_en = 1'b1; c.comb_long = 1'b1; c.a2 = TAP_NEG; end
      3'd4: begin c.comb_en = 1'b1; c.a1 = TAP_POS; end
      3'd5: begin c.comb_en = 1'b1; c.b0 = TAP_EIGHTH; c.a1 = TAP_POS; end
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pmf_comb.sv
module pmf_comb
  import pmf_pkg::*;
#(
  parameter int SHORT_N = 8,
  parameter int LONG_N  = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic take,
  input  logic comb_en,
  input  logic comb_long,
  input  fp_t  x,
  output logic v_valid,
  output fp_t  v_data
);
  localparam int DEPTH = LONG_N;

  fp_t line [DEPTH];
  fp_t x_c, x_old, v_next;

  assign x_c    = fp_canon(x);
  assign x_old  = comb_long ? line[LONG_N-1] : line[SHORT_N-1];
  assign v_next = comb_en ? fp_add(x_c, fp_neg(x_old)) : x_c;

  always_ff @(posedge clk) begin
    if (clr) line[0] <= '0;
    else if (take) line[0] <= x_c;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (clr) line[k] <= '0;
      else if (take) line[k] <= line[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      v_valid <= 1'b0;
      v_data  <= '0;
    end else begin
      v_valid <= take;
      if (take) v_data <= v_next;
    end
  end

  // R9 / R3: with the comb off the stage forwards the canonical sample
  a_r9_comb_off: assert property (@(posedge clk) disable iff (clr)
    (take && !comb_en) |=> (v_valid && v_data == fp_canon($past(x))));
endmodule

// File: rtl/pmf_sos.sv
module pmf_sos
  import pmf_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic v_valid,
  input  fp_t  v_data,
  input  cfg_t cfg,
  output logic y_valid,
  output fp_t  y_data
);
  fp_t v1, y1, y2;
  fp_t t_b0, t_b1, t_a1, t_a2, sum_ff, sum_all;

  assign t_b0    = fp_tap(cfg.b0, v_data);
  assign t_b1    = fp_tap(cfg.b1, v1);
  assign t_a1    = fp_tap(cfg.a1, y1);
  assign t_a2    = fp_tap(cfg.a2, y2);
  assign sum_ff  = fp_add(t_b0, t_b1);
  assign sum_all = fp_add(fp_add(sum_ff, t_a1), t_a2);

  always_ff @(posedge clk) begin
    if (clr) begin
      y_valid <= 1'b0;
      v1 <= '0;
      y1 <= '0;
      y2 <= '0;
    end else begin
      y_valid <= v_valid;
      if (v_valid) begin
        v1 <= v_data;
        y1 <= sum_all;
        y2 <= y1;
      end
    end
  end

  assign y_data = y1;

  // R1: no output word carries a zero exponent with other bits set
  a_r1_canonical_zero: assert property (@(posedge clk) disable iff (clr)
    y_valid |-> (y_data[DW-2:FW] != '0 || y_data == '0));
endmodule

// File: rtl/pmf_filter_top.sv
module pmf_filter_top
  import pmf_pkg::*;
#(
  parameter int SHORT_N = 8,
  parameter int LONG_N  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [2:0] mode_q;
  logic mode_chg, clr, take, v_valid;
  fp_t  v_data;
  cfg_t cfg;

  always_ff @(posedge clk) mode_q <= mode;

  assign mode_chg = !rst && (mode != mode_q);
  assign clr      = rst || mode_chg;
  assign take     = in_valid && !mode_chg;
  assign cfg      = mode_cfg(mode_q);

  pmf_comb #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) u_comb (
    .clk(clk), .clr(clr), .take(take),
    .comb_en(cfg.comb_en), .comb_long(cfg.comb_long),
    .x(in_data), .v_valid(v_valid), .v_data(v_data)
  );

  pmf_sos u_sos (
    .clk(clk), .clr(clr), .v_valid(v_valid), .v_data(v_data),
    .cfg(cfg), .y_valid(out_valid), .y_data(out_data)
  );

  // R10: every output strobe traces back to an input two cycles earlier
  a_r10_no_orphan: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  // R10: an accepted input not disturbed by a mode change comes out
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    (take ##1 !mode_chg) |=> out_valid);
  // R11: a mode change leaves an empty, zeroed output
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (!out_valid && out_data == '0));
endmodule

// File: tb/pmf_filter_top_tb.sv
module pmf_filter_top_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [11:0] in_data = 12'h000;
  logic out_valid;
  logic [11:0] out_data;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pmf_filter_top u_dut (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  // bench model state
  logic [11:0] xh [16];
  logic [11:0] mv1, my1, my2;
  logic [2:0] cur_mode = 3'd0;
  bit p0_v = 0, p1_v = 0;
  logic [11:0] p0_d, p1_d;
  string p0_t, p1_t;
  bit zero_chk = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [11:0] m_add(logic [11:0] a, logic [11:0] b);
    int ea, eb, e, vl, vs, sl, ss, s, mag;
    ea = int'(a[10:5]); eb = int'(b[10:5]);
    if (ea == 0 && eb == 0) return 12'h000;
    if (ea == 0) return b;
    if (eb == 0) return a;
    if (ea > eb || (ea == eb && a[4:0] >= b[4:0])) begin
      e = ea; vl = 32 + int'(a[4:0]); vs = (32 + int'(b[4:0])) >> (ea - eb);
      sl = a[11] ? -1 : 1; ss = b[11] ? -1 : 1;
    end else begin
      e = eb; vl = 32 + int'(b[4:0]); vs = (32 + int'(a[4:0])) >> (eb - ea);
      sl = b[11] ? -1 : 1; ss = a[11] ? -1 : 1;
    end
    s = sl * vl + ss * vs;
    if (s == 0) return 12'h000;
    mag = (s < 0) ? -s : s;
    while (mag >= 64) begin mag = mag >> 1; e++; end
    while (mag < 32) begin mag = mag << 1; e--; end
    if (e > 63) return {s < 0, 11'h7FF};
    if (e < 1) return 12'h000;
    return {s < 0, 6'(e), 5'(mag - 32)};
  endfunction

  // coefficient code: 0 none, 1 plus one, -1 minus one, 8 one eighth
  function automatic logic [11:0] m_mul(int c, logic [11:0] x);
    if (x[10:5] == 6'd0 || c == 0) return 12'h000;
    if (c == 1) return x;
    if (c == -1) return {~x[11], x[10:0]};
    if (int'(x[10:5]) < 4) return 12'h000;
    return {x[11], x[10:5] - 6'd3, x[4:0]};
  endfunction

  function automatic logic [11:0] model(logic [11:0] x_in);
    int n, b0, b1, a1, a2;
    logic [11:0] x, v, y;
    n = 0; b0 = 1; b1 = 0; a1 = 0; a2 = 0;
    case (cur_mode)
      3'd0: b1 = -1;
      3'd1: a1 = 1;
      3'd2: n = 8;
      3'd3: begin n = 16; a2 = -1; end
      3'd4: begin n = 8; a1 = 1; end
      3'd5: begin n = 8; b0 = 8; a1 = 1; end
      default: ;
    endcase
    x = (x_in[10:5] == 6'd0) ? 12'h000 : x_in;
    v = (n == 0) ? x : m_add(x, m_mul(-1, xh[n-1]));
    y = m_add(m_add(m_add(m_mul(b0, v), m_mul(b1, mv1)), m_mul(a1, my1)), m_mul(a2, my2));
    for (int k = 15; k > 0; k--) xh[k] = xh[k-1];
    xh[0] = x;
    mv1 = v; my2 = my1; my1 = y;
    return y;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 16; k++) xh[k] = 12'h000;
    mv1 = 12'h000; my1 = 12'h000; my2 = 12'h000;
  endtask

  task automatic fail(string req, logic [11:0] act, logic [11:0] exp);
    n_bad++;
    $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
  endtask

  // one cycle: check outputs, then drive the next inputs
  task automatic step(bit v, logic [11:0] d, logic [2:0] m);
    @(negedge clk);
    n_vec++;
    if (out_valid !== p1_v) fail({p1_t, " valid"}, {11'h0, out_valid}, {11'h0, p1_v});
    else if (p1_v && out_data !== p1_d) fail(p1_t, out_data, p1_d);
    if (zero_chk) begin
      n_vec++;
      if (out_data !== 12'h000) fail("R11 clear", out_data, 12'h000);
      zero_chk = 0;
    end
    mode = m; in_valid = v; in_data = d;
    if (m != cur_mode) begin
      cur_mode = m; model_clear();
      p1_v = 0; p0_v = 0; zero_chk = 1;
      p1_t = "R11 discard";
    end else begin
      p1_v = p0_v; p1_d = p0_d; p1_t = p0_t;
      p0_v = v; p0_t = tag_of(m);
      if (v) p0_d = model(d);
    end
  endtask

  task automatic check_lit(string req, logic [11:0] exp);
    n_vec++;
    if (out_data !== exp) fail(req, out_data, exp);
  endtask

  function automatic logic [11:0] rnd_sample();
    int r, e;
    seed = seed * 32'd1103515245 + 32'd12345;
    r = int'(seed[30:16]);
    case (r % 10)
      0: e = 0;
      1: e = 62;
      2: e = 2 + (r / 10) % 3;
      default: e = 27 + (r / 10) % 9;
    endcase
    return {seed[13], 6'(e), seed[20:16]};
  endfunction

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R12: reset state
    n_vec++;
    if (out_valid !== 1'b0) fail("R12 valid", {11'h0, out_valid}, 12'h000);
    check_lit("R12 data", 12'h000);
    rst = 1'b0;
    step(0, 12'h000, 3'd0);
    check_lit("R12 after release", 12'h000);

    // sweep every mode code with a gapped random stream (R2..R10)
    for (int m = 0; m < 8; m++) begin
      step(0, 12'h000, 3'(m));
      step(0, 12'h000, 3'(m));
      for (int i = 0; i < 60; i++)
        step((i % 7) != 6, rnd_sample(), 3'(m));
      step(0, 12'h000, 3'(m));
      step(0, 12'h000, 3'(m));
    end

    // R2: integrator saturates to the largest magnitude
    step(0, 12'h000, 3'd1);
    repeat (4) step(1, 12'h7C0, 3'd1);
    step(0, 12'h000, 3'd1);
    step(0, 12'h000, 3'd1);
    check_lit("R2 saturate", 12'h7FF);

    // R8: one-eighth tap flushes a tiny exponent to zero
    step(0, 12'h000, 3'd5);
    step(1, 12'h060, 3'd5);
    step(0, 12'h000, 3'd5);
    step(0, 12'h000, 3'd5);
    check_lit("R8 flush", 12'h000);

    // R1: exponent-zero word passes as canonical zero
    step(0, 12'h000, 3'd7);
    step(1, 12'h81F, 3'd7);
    step(0, 12'h000, 3'd7);
    step(0, 12'h000, 3'd7);
    check_lit("R1 zero", 12'h000);

    // R11: valid input in the mode-change cycle is dropped, in-flight cleared
    step(1, 12'h3E5, 3'd7);
    step(1, 12'h3E5, 3'd2);
    step(0, 12'h000, 3'd2);
    step(0, 12'h000, 3'd2);
    step(0, 12'h000, 3'd2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule